// File: doc/BRIEF.md
# ARINC 429 Receive Word Assembler and Host Readout

This block sits behind a bit validator on an ARINC 429 receive channel. Each validated data bit arrives as a one-cycle strobe with its value. The block places the bits into a 32-bit assembly register, counts them, and overwrites the last bit with a locally computed parity result. An optional label filter compares ARINC bits 9 and 10 against two programmed bits. A finished word that passes the filter is copied into a holding register, and an active-low data-ready flag is raised.

A host collects the held word as two 16-bit halves. It drives a read enable low and uses a half selector to choose the half. The data-ready flag returns high only once both halves have been read since the most recent capture. A newer word that arrives before the host has finished replaces the held word without warning. An abort indication from the bit validator throws away any partly assembled word.

Top module: `arw_word_rx`

## Requirements
- R1: The first bit strobed after reset or after a completed or aborted word is ARINC bit 1 and is stored at index 0. ARINC bit n is stored at index n-1. The word completes on the 32nd strobe.
- R2: Index 31 of a stored word holds a parity result, not the received bit. It is 0 when the number of ones among all 32 received bits, the received bit 32 included, is odd, and 1 when that number is even.
- R3: When `decodeEn` is 1, a completed word is captured only if ARINC bit 9 (index 8) equals `matchBits[0]` and ARINC bit 10 (index 9) equals `matchBits[1]`. When `decodeEn` is 0, every completed word is captured.
- R4: `dataReadyN` goes low in the cycle after a capture. It stays low until both halves have been read, and a single half read, however often repeated, leaves it low.
- R5: While `readEnN` is 0, `readData` returns indices 15:0 of the held word if `halfSel` is 0 and indices 31:16 if `halfSel` is 1. While `readEnN` is 1, `readData` is all zeros.
- R6: A read counts for its half on the first clock edge at which `readEnN` is sampled high after being low. The half counted is the one `halfSel` selected during the last low cycle. `dataReadyN` rises at the edge that counts the second distinct half.
- R7: A new capture before both halves are read replaces the held word and keeps `dataReadyN` low.
- R8: Each capture clears the record of halves already read, so a half read before the capture does not count toward the new word.
- R9: A high `seqAbort` discards the bits assembled so far, and the next strobe is treated as ARINC bit 1. A strobe in the same cycle as `seqAbort` is ignored.
- R10: After reset, `dataReadyN` is 1 and the held word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStrobe | input | 1 | One-cycle strobe for a validated data bit |
| bitValue | input | 1 | Value of the strobed bit |
| seqAbort | input | 1 | Error or word-start indication; discards a partial word |
| decodeEn | input | 1 | Enables the bits 9/10 label filter |
| matchBits | input | 2 | Filter values: [0] for ARINC bit 9, [1] for ARINC bit 10 |
| readEnN | input | 1 | Host read enable, active low |
| halfSel | input | 1 | Half selector: 0 for the low half, 1 for the high half |
| readData | output | 16 | Selected half of the held word, or zero when not enabled |
| dataReadyN | output | 1 | Word available, active low |

## Verification
The assertions assume that each bit strobe lasts one cycle, that the filter inputs stay steady while a word completes, and that the host holds `halfSel` steady during each low period of `readEnN` and returns `readEnN` high between reads. The stimulus drives every input on the falling clock edge. It spaces the strobes with an idle cycle and wraps each host read in one low cycle followed by a high cycle, so the release edge is always seen. The directed part covers reads interleaved with captures, repeated single-half reads and aborts in mid-word.

// File: rtl/arw_pkg.sv
package arw_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam int LABEL_LO = 8;   // index of ARINC bit 9
  localparam int LABEL_HI = 9;   // index of ARINC bit 10

  typedef struct packed {
    logic             shiftEn;
    logic [CNT_W-1:0] bitIdx;
    logic             bitVal;
    logic             latchEn;
  } arwStrobe_t;
endpackage

// File: rtl/arw_ctrl.sv
module arw_ctrl
  import arw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       bitValue,
  input  logic       seqAbort,
  input  logic       decodeEn,
  input  logic       matchHit,
  input  logic       readEnN,
  input  logic       halfSel,
  output arwStrobe_t strobe,
  output logic       dataReadyN
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             parityAcc;
  logic             lastBit;
  logic             endOfSeq;
  logic             rdActiveQ;
  logic             selQ;
  logic             gotLo;
  logic             gotHi;
  logic             ready;
  logic             readRelease;

  assign lastBit     = (bitCnt == LAST_IDX);
  assign endOfSeq    = bitStrobe & ~seqAbort & lastBit;
  assign readRelease = rdActiveQ & readEnN;

  always_comb begin
    strobe.shiftEn = bitStrobe & ~seqAbort;
    strobe.bitIdx  = bitCnt;
    strobe.bitVal  = lastBit ? ~(parityAcc ^ bitValue) : bitValue;
    strobe.latchEn = endOfSeq & (~decodeEn | matchHit);
  end

  // bit counter and running parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      parityAcc <= 1'b0;
    end else if (seqAbort) begin
      bitCnt    <= '0;
      parityAcc <= 1'b0;
    end else if (bitStrobe) begin
      if (lastBit) begin
        bitCnt    <= '0;
        parityAcc <= 1'b0;
      end else begin
        bitCnt    <= bitCnt + 1'b1;
        parityAcc <= parityAcc ^ bitValue;
      end
    end
  end

  // host read tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActiveQ <= 1'b0;
      selQ      <= 1'b0;
      gotLo     <= 1'b0;
      gotHi     <= 1'b0;
      ready     <= 1'b0;
    end else begin
      rdActiveQ <= ~readEnN;
      if (!readEnN) selQ <= halfSel;
      if (strobe.latchEn) begin
        ready <= 1'b1;
        gotLo <= 1'b0;
        gotHi <= 1'b0;
      end else if (readRelease) begin
        if (selQ) begin
          gotHi <= 1'b1;
          if (gotLo) ready <= 1'b0;
        end else begin
          gotLo <= 1'b1;
          if (gotHi) ready <= 1'b0;
        end
      end
    end
  end

  assign dataReadyN = ~ready;

  assert_abort_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |=> (bitCnt == '0));

  assert_capture_raises_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchEn |=> !dataReadyN);
endmodule

// File: rtl/arw_datapath.sv
module arw_datapath
  import arw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  arwStrobe_t        strobe,
  input  logic [1:0]        matchBits,
  input  logic              readEnN,
  input  logic              halfSel,
  output logic              matchHit,
  output logic [HALF_W-1:0] readData
);
  logic [WORD_W-1:0] asmReg;
  logic [WORD_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg  <= '0;
      holdReg <= '0;
    end else begin
      if (strobe.shiftEn) asmReg[strobe.bitIdx] <= strobe.bitVal;
      if (strobe.latchEn) holdReg <= {strobe.bitVal, asmReg[WORD_W-2:0]};
    end
  end

  assign matchHit = (asmReg[LABEL_LO] == matchBits[0]) &&
                    (asmReg[LABEL_HI] == matchBits[1]);

  always_comb begin
    if (readEnN)      readData = '0;
    else if (halfSel) readData = holdReg[WORD_W-1:HALF_W];
    else              readData = holdReg[HALF_W-1:0];
  end
endmodule

// File: rtl/arw_word_rx.sv
module arw_word_rx
  import arw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              bitValue,
  input  logic              seqAbort,
  input  logic              decodeEn,
  input  logic [1:0]        matchBits,
  input  logic              readEnN,
  input  logic              halfSel,
  output logic [HALF_W-1:0] readData,
  output logic              dataReadyN
);
  arwStrobe_t strobe;
  logic       matchHit;

  arw_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .bitStrobe  (bitStrobe),
    .bitValue   (bitValue),
    .seqAbort   (seqAbort),
    .decodeEn   (decodeEn),
    .matchHit   (matchHit),
    .readEnN    (readEnN),
    .halfSel    (halfSel),
    .strobe     (strobe),
    .dataReadyN (dataReadyN)
  );

  arw_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .matchBits (matchBits),
    .readEnN   (readEnN),
    .halfSel   (halfSel),
    .matchHit  (matchHit),
    .readData  (readData)
  );

  assert_filter_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchEn && decodeEn) |-> matchHit);

  assert_ready_only_from_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReadyN) |-> $past(strobe.latchEn));

  assert_ready_drop_on_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReadyN) |-> ($past(readEnN) && !$past(readEnN, 2)));

  assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    readEnN |-> (readData == '0));
endmodule

// File: tb/arw_word_rx_tb_top.sv
module arw_word_rx_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        bitValue = 1'b0;
  logic        seqAbort = 1'b0;
  logic        decodeEn = 1'b0;
  logic [1:0]  matchBits = 2'b00;
  logic        readEnN = 1'b1;
  logic        halfSel = 1'b0;
  logic [15:0] readData;
  logic        dataReadyN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arw_word_rx dut_i (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitValue(bitValue),
    .seqAbort(seqAbort), .decodeEn(decodeEn), .matchBits(matchBits),
    .readEnN(readEnN), .halfSel(halfSel), .readData(readData),
    .dataReadyN(dataReadyN)
  );

  // {expectCapture, decodeEn, matchBits[1:0], word}
  localparam int NVEC = 7;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'b00, 32'h0000_0000},
    {1'b1, 1'b0, 2'b00, 32'h8000_0001},
    {1'b1, 1'b1, 2'b11, 32'h0000_0301},
    {1'b0, 1'b1, 2'b11, 32'hFFFF_FCFF},
    {1'b1, 1'b1, 2'b10, 32'h1234_5600},
    {1'b1, 1'b0, 2'b00, 32'hA5A5_A5A5},
    {1'b0, 1'b1, 2'b10, 32'h0000_0100}
  };

  function automatic logic [31:0] stored(input logic [31:0] w);
    return {~(^w), w[30:0]};   // R2 parity rule
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitStrobe = 1'b1; bitValue = w[i];
      @(negedge clk); bitStrobe = 1'b0;
    end
  endtask

  task automatic readHalf(input logic sel, output logic [15:0] val);
    @(negedge clk); halfSel = sel; readEnN = 1'b0;
    @(negedge clk); val = readData; readEnN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lo, hi;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", {31'd0, dataReadyN}, 32'd1);
    readHalf(1'b0, lo); readHalf(1'b1, hi);
    check("R10 held word after reset", {hi, lo}, 32'd0);
    check("R10 no ready from reads", {31'd0, dataReadyN}, 32'd1);
    held = 32'd0;

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      decodeEn  = VEC[v][34];
      matchBits = VEC[v][33:32];
      sendBits(VEC[v][31:0], 32);
      @(negedge clk);
      if (VEC[v][35]) begin
        held = stored(VEC[v][31:0]);
        check("R3/R4 ready after capture", {31'd0, dataReadyN}, 32'd0);
      end else begin
        check("R3 filtered word not ready", {31'd0, dataReadyN}, 32'd1);
      end
      readHalf(1'b0, lo);
      check("R4 ready held after one half", {31'd0, dataReadyN}, {31'd0, ~VEC[v][35]});
      readHalf(1'b1, hi);
      check("R1/R2/R5 word readback", {hi, lo}, held);
      check("R6 ready released after both", {31'd0, dataReadyN}, 32'd1);
    end
    decodeEn = 1'b0;

    // R5 idle bus with enable high
    halfSel = 1'b1; @(negedge clk);
    check("R5 zero when not enabled", {16'd0, readData}, 32'd0);

    // R4 repeated low-half reads do not release
    sendBits(32'h0F0F_1234, 32);
    readHalf(1'b0, lo); readHalf(1'b0, lo); readHalf(1'b0, lo);
    check("R4 repeated same half keeps ready", {31'd0, dataReadyN}, 32'd0);
    readHalf(1'b1, hi);
    check("R6 second half releases", {31'd0, dataReadyN}, 32'd1);

    // R7 overwrite of unread word
    sendBits(32'h1111_1111, 32);
    sendBits(32'h7654_3210, 32);
    check("R7 ready stays low", {31'd0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo); readHalf(1'b1, hi);
    check("R7 newer word held", {hi, lo}, stored(32'h7654_3210));

    // R8 tracking cleared by capture
    sendBits(32'h0000_00FF, 32);
    readHalf(1'b0, lo);
    sendBits(32'hFF00_0000, 32);
    readHalf(1'b1, hi);
    check("R8 stale half not counted", {31'd0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo);
    check("R8 release after both new halves", {31'd0, dataReadyN}, 32'd1);
    check("R8 new word data", {hi, lo}, stored(32'hFF00_0000));

    // R9 abort discards partial word
    sendBits(32'hFFFF_FFFF, 10);
    @(negedge clk); seqAbort = 1'b1; bitStrobe = 1'b1; bitValue = 1'b1;
    @(negedge clk); seqAbort = 1'b0; bitStrobe = 1'b0;
    check("R9 no capture after abort", {31'd0, dataReadyN}, 32'd1);
    sendBits(32'h0000_0006, 32);
    check("R9 ready after clean word", {31'd0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo); readHalf(1'b1, hi);
    check("R9/R1 realigned word", {hi, lo}, stored(32'h0000_0006));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule